// File: doc/BRIEF.md
# Peripheral Slot ROM Selector

This block steers reads in the peripheral ROM space, pages 0xC1 through 0xCF of a 16-bit address map. For every read there it decides whether the data comes from the internal firmware ROM or from the ROM on a peripheral card. Two soft switches drive that choice. They are set and cleared by writes to the soft-switch page 0xC0. A sticky expansion flag also takes part: reading internal ROM on the slot-3 page arms it, and reading internal ROM at byte 0xCFFF disarms it. While the flag is armed and the internal override is off, the shared expansion window 0xC8 to 0xCF is taken by internal ROM.

A single access port (page, offset, read strobe, write strobe) feeds the block. It returns a registered select for each read in the slot range. It also keeps a registered map with one bit per slot page, showing where a read of that page would go right now. Status reads on page 0xC0 return the two switch states in bit 7. The ROM arrays and the slot cards are outside the block. Writes to pages 0xC1 to 0xCF never change anything.

Top module: `slot_rom_steer`

## Requirements
- R1: After synchronous reset the internal override, the slot-3 switch and the sticky flag are all clear, `page_map` equals 15'h0004 (only page 0xC3 internal), and `sel_vld` and `stat_vld` are low.
- R2: A write to page 0xC0 offset 0x06 clears the internal override and also disarms the sticky flag. A write to offset 0x07 sets the override and leaves the sticky flag unchanged.
- R3: A write to page 0xC0 offset 0x0A clears the slot-3 switch. A write to offset 0x0B sets it.
- R4: While the internal override is set, every page 0xC1 to 0xCF selects internal ROM (`page_map` all ones, `sel_int` high for any read there).
- R5: While the override is clear, pages select slot ROM. The exception is page 0xC3, which selects internal ROM while the slot-3 switch is clear.
- R6: While the override is clear and the sticky flag is armed, pages 0xC8 to 0xCF select internal ROM.
- R7: A read of page 0xC3 that selects internal ROM arms the sticky flag. A read of 0xCFFF that selects internal ROM disarms it. The triggering read itself is routed with the flag value it found, and the change applies from the next access. `page_map` shows it one cycle after the read.
- R8: A read of page 0xC0 offset 0x15 gives `stat_vld` high the next cycle, with `stat_byte` 0x80 if the override is set, else 0x00. Offset 0x17 reports the slot-3 switch the same way. Every other bit of `stat_byte` is zero.
- R9: Writes to pages 0xC1 to 0xCF change neither switch nor the sticky flag, whatever the offset.
- R10: When read and write strobes are both high, only the write acts. The read produces no select, no status and no sticky change.
- R11: `sel_vld` rises in the cycle after a read of pages 0xC1 to 0xCF only. For any other read it stays low, and `sel_int` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_page | input | 8 | Upper address byte of the access |
| bus_off | input | 8 | Lower address byte of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, wins over `bus_rd` |
| sel_vld | output | 1 | Registered: previous cycle was a read in the slot range |
| sel_int | output | 1 | Registered: that read goes to internal ROM (1) or slot ROM (0) |
| page_map | output | 15 | Registered: bit i set means page 0xC1+i currently reads internal ROM |
| stat_vld | output | 1 | Registered: previous cycle was a status read |
| stat_byte | output | 8 | Registered status value, switch state in bit 7 |

## Verification
Routing a read and updating the sticky flag happen in the same cycle on the two trigger addresses. A read of 0xCFFF with the flag armed must still go to internal ROM, while `page_map` in the very next cycle already shows the window released. The same holds when the override is set, which keeps the page internal but still disarms the flag. The bench drives every combination of override, slot-3 switch and sticky flag, then sweeps all fifteen pages plus the two trigger addresses. It compares each select against the state before the access and each map against the state after it.

// File: rtl/slotsel_pkg.sv
package slotsel_pkg;

  // Routing state shared by the selector's sub-blocks.
  typedef struct packed {
    logic intcx;   // internal override for the whole slot range
    logic slot3;   // slot-3 card ROM enabled
    logic sticky;  // expansion window owned by internal ROM
  } route_flags_t;

endpackage

// File: rtl/slotsel_switches.sv
module slotsel_switches #(
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned SW_PAGE    = 'hC0,
  parameter int unsigned OFF_IX_CLR = 'h06,
  parameter int unsigned OFF_IX_SET = 'h07,
  parameter int unsigned OFF_S3_CLR = 'h0A,
  parameter int unsigned OFF_S3_SET = 'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  output logic              intcx_q,
  output logic              slot3_q,
  output logic              intcx_d,
  output logic              slot3_d,
  output logic              sticky_clr
);

  logic sw_hit;
  logic ix_clr, ix_set, s3_clr, s3_set;

  assign sw_hit = wr_en && (page == PAGE_W'(SW_PAGE));
  assign ix_clr = sw_hit && (off == OFF_W'(OFF_IX_CLR));
  assign ix_set = sw_hit && (off == OFF_W'(OFF_IX_SET));
  assign s3_clr = sw_hit && (off == OFF_W'(OFF_S3_CLR));
  assign s3_set = sw_hit && (off == OFF_W'(OFF_S3_SET));

  assign sticky_clr = ix_clr;

  always_comb begin
    intcx_d = intcx_q;
    slot3_d = slot3_q;
    if (ix_clr) intcx_d = 1'b0;
    else if (ix_set) intcx_d = 1'b1;
    if (s3_clr) slot3_d = 1'b0;
    else if (s3_set) slot3_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intcx_q <= 1'b0;
      slot3_q <= 1'b0;
    end else begin
      intcx_q <= intcx_d;
      slot3_q <= slot3_d;
    end
  end

  AST_IX_SET: assert property (@(posedge clk) disable iff (rst)
    ix_set |=> intcx_q); // R2
  AST_IX_CLR: assert property (@(posedge clk) disable iff (rst)
    ix_clr |=> !intcx_q); // R2
  AST_S3_SET: assert property (@(posedge clk) disable iff (rst)
    s3_set |=> slot3_q); // R3
  AST_S3_CLR: assert property (@(posedge clk) disable iff (rst)
    s3_clr |=> !slot3_q); // R3

endmodule

// File: rtl/slotsel_route.sv
module slotsel_route
  import slotsel_pkg::*;
#(
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned S3_PAGE = 'hC3,
  parameter int unsigned WIN_LO  = 'hC8,
  parameter int unsigned WIN_HI  = 'hCF
) (
  input  logic [PAGE_W-1:0] page,
  input  route_flags_t      flags,
  output logic              internal
);

  logic is_s3, in_win;

  assign is_s3  = (page == PAGE_W'(S3_PAGE));
  assign in_win = (page >= PAGE_W'(WIN_LO)) && (page <= PAGE_W'(WIN_HI));

  always_comb begin
    if (flags.intcx)
      internal = 1'b1;
    else if (is_s3)
      internal = !flags.slot3;
    else
      internal = flags.sticky && in_win;
  end

endmodule

// File: rtl/slotsel_sticky.sv
module slotsel_sticky (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic disarm,
  input  logic clr,
  output logic sticky_q,
  output logic sticky_d
);

  always_comb begin
    sticky_d = sticky_q;
    if (clr || disarm) sticky_d = 1'b0;
    else if (arm)      sticky_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sticky_q <= 1'b0;
    else     sticky_q <= sticky_d;
  end

  AST_STICKY_ARM: assert property (@(posedge clk) disable iff (rst)
    (arm && !clr && !disarm) |=> sticky_q); // R7
  AST_STICKY_DISARM: assert property (@(posedge clk) disable iff (rst)
    disarm |=> !sticky_q); // R7
  AST_STICKY_SWCLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sticky_q); // R2

endmodule

// File: rtl/slotsel_status.sv
module slotsel_status #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_BIT = 7,
  parameter int unsigned SW_PAGE  = 'hC0,
  parameter int unsigned OFF_IX_Q = 'h15,
  parameter int unsigned OFF_S3_Q = 'h17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  input  logic              intcx,
  input  logic              slot3,
  output logic              stat_vld,
  output logic [DATA_W-1:0] stat_byte
);

  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  logic on_page, q_ix, q_s3;

  assign on_page = rd_en && (page == PAGE_W'(SW_PAGE));
  assign q_ix    = on_page && (off == OFF_W'(OFF_IX_Q));
  assign q_s3    = on_page && (off == OFF_W'(OFF_S3_Q));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_vld  <= 1'b0;
      stat_byte <= '0;
    end else begin
      stat_vld <= q_ix || q_s3;
      if (q_ix)      stat_byte <= intcx ? FLAG_MASK : '0;
      else if (q_s3) stat_byte <= slot3 ? FLAG_MASK : '0;
      else           stat_byte <= '0;
    end
  end

  AST_STAT_ONLY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (stat_byte & ~FLAG_MASK) == '0); // R8
  AST_STAT_IX: assert property (@(posedge clk) disable iff (rst)
    q_ix |=> (stat_vld && ((stat_byte != '0) == $past(intcx)))); // R8

endmodule

// File: rtl/slot_rom_steer.sv
module slot_rom_steer
  import slotsel_pkg::*;
#(
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned FIRST_PAGE = 'hC1,
  parameter int unsigned LAST_PAGE  = 'hCF,
  parameter int unsigned S3_PAGE    = 'hC3,
  parameter int unsigned WIN_LO     = 'hC8,
  parameter int unsigned SW_PAGE    = 'hC0,
  parameter int unsigned LAST_OFF   = 'hFF,
  parameter int unsigned NPAGE      = LAST_PAGE - FIRST_PAGE + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAGE_W-1:0] bus_page,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              sel_vld,
  output logic              sel_int,
  output logic [NPAGE-1:0]  page_map,
  output logic              stat_vld,
  output logic [DATA_W-1:0] stat_byte
);

  localparam logic [PAGE_W-1:0] PG_FIRST = PAGE_W'(FIRST_PAGE);
  localparam logic [PAGE_W-1:0] PG_LAST  = PAGE_W'(LAST_PAGE);

  // A read is honoured only when no write shares the cycle.
  logic rd_acc, in_range, route_now;
  logic intcx_q, slot3_q, intcx_d, slot3_d, sticky_q, sticky_d, sticky_clr;
  logic arm, disarm;
  route_flags_t flags_q, flags_d;
  logic [NPAGE-1:0] map_d;

  assign rd_acc   = bus_rd && !bus_wr;
  assign in_range = (bus_page >= PG_FIRST) && (bus_page <= PG_LAST);

  slotsel_switches #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SW_PAGE(SW_PAGE)
  ) u_sw (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .page(bus_page), .off(bus_off),
    .intcx_q(intcx_q), .slot3_q(slot3_q), .intcx_d(intcx_d),
    .slot3_d(slot3_d), .sticky_clr(sticky_clr)
  );

  assign flags_q = '{intcx: intcx_q, slot3: slot3_q, sticky: sticky_q};
  assign flags_d = '{intcx: intcx_d, slot3: slot3_d, sticky: sticky_d};

  // Route of the current access, judged on the flags as they stand.
  slotsel_route #(
    .PAGE_W(PAGE_W), .S3_PAGE(S3_PAGE), .WIN_LO(WIN_LO), .WIN_HI(LAST_PAGE)
  ) u_route_now (
    .page(bus_page), .flags(flags_q), .internal(route_now)
  );

  assign arm    = rd_acc && route_now && (bus_page == PAGE_W'(S3_PAGE));
  assign disarm = rd_acc && route_now && (bus_page == PG_LAST) &&
                  (bus_off == OFF_W'(LAST_OFF));

  slotsel_sticky u_sticky (
    .clk(clk), .rst(rst), .arm(arm), .disarm(disarm), .clr(sticky_clr),
    .sticky_q(sticky_q), .sticky_d(sticky_d)
  );

  // Per-page map built from the next-state flags so it is registered yet
  // aligned with the flag registers.
  for (genvar gi = 0; gi < NPAGE; gi++) begin : g_map
    slotsel_route #(
      .PAGE_W(PAGE_W), .S3_PAGE(S3_PAGE), .WIN_LO(WIN_LO), .WIN_HI(LAST_PAGE)
    ) u_route_pg (
      .page(PAGE_W'(FIRST_PAGE + gi)), .flags(flags_d), .internal(map_d[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld  <= 1'b0;
      sel_int  <= 1'b0;
      page_map <= NPAGE'(1) << (S3_PAGE - FIRST_PAGE);
    end else begin
      sel_vld  <= rd_acc && in_range;
      sel_int  <= rd_acc && in_range && route_now;
      page_map <= map_d;
    end
  end

  slotsel_status #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .SW_PAGE(SW_PAGE)
  ) u_stat (
    .clk(clk), .rst(rst), .rd_en(rd_acc), .page(bus_page), .off(bus_off),
    .intcx(intcx_q), .slot3(slot3_q), .stat_vld(stat_vld),
    .stat_byte(stat_byte)
  );

  AST_OVERRIDE_ALL: assert property (@(posedge clk) disable iff (rst)
    intcx_q |-> (&page_map)); // R4
  AST_WIN_STICKY: assert property (@(posedge clk) disable iff (rst)
    sticky_q |-> (&page_map[NPAGE-1:WIN_LO-FIRST_PAGE])); // R6
  AST_SLOTWR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_range) |=> $stable(page_map)); // R9
  AST_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> (!sel_vld && !stat_vld)); // R10
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && in_range) |=> (!sel_vld && !sel_int)); // R11
  AST_SEL_IMPLIES_VLD: assert property (@(posedge clk) disable iff (rst)
    sel_int |-> sel_vld); // R11

endmodule

// File: tb/slot_rom_steer_tb.sv
module slot_rom_steer_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_page, bus_off;
  logic        bus_rd, bus_wr;
  logic        sel_vld, sel_int, stat_vld;
  logic [14:0] page_map;
  logic [7:0]  stat_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state from the requirements
  bit m_ix, m_s3, m_st;

  always #5 clk = ~clk;

  slot_rom_steer u_dut (
    .clk(clk), .rst(rst), .bus_page(bus_page), .bus_off(bus_off),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .sel_vld(sel_vld), .sel_int(sel_int),
    .page_map(page_map), .stat_vld(stat_vld), .stat_byte(stat_byte)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_int(input logic [7:0] p);
    return m_ix || (p == 8'hC3 && !m_s3) || (m_st && p >= 8'hC8 && p <= 8'hCF);
  endfunction

  function automatic logic [14:0] exp_map();
    logic [14:0] m;
    for (int i = 0; i < 15; i++) m[i] = exp_int(8'(8'hC1 + i));
    return m;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_page = 0; bus_off = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    m_ix = 0; m_s3 = 0; m_st = 0;
  endtask

  task automatic acc(input string tag, input logic [7:0] p, input logic [7:0] o,
                     input bit r, input bit w);
    bit inr, rv, ev, es, sv;
    logic [7:0] sb;
    inr = (p >= 8'hC1 && p <= 8'hCF);
    rv  = r && !w;
    ev  = rv && inr;
    es  = ev && exp_int(p);
    sv  = rv && p == 8'hC0 && (o == 8'h15 || o == 8'h17);
    sb  = !sv ? 8'h00 : (o == 8'h15 ? (m_ix ? 8'h80 : 8'h00) : (m_s3 ? 8'h80 : 8'h00));
    @(negedge clk);
    bus_page = p; bus_off = o; bus_rd = r; bus_wr = w;
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0;
    // state after the access
    if (w && p == 8'hC0) begin
      if (o == 8'h06) begin m_ix = 0; m_st = 0; end
      if (o == 8'h07) m_ix = 1;
      if (o == 8'h0A) m_s3 = 0;
      if (o == 8'h0B) m_s3 = 1;
    end
    if (es && p == 8'hC3) m_st = 1;
    if (es && p == 8'hCF && o == 8'hFF) m_st = 0;
    chk(tag, "sel_vld", 32'(sel_vld), 32'(ev));
    chk(tag, "sel_int", 32'(sel_int), 32'(es));
    chk(tag, "stat_vld", 32'(stat_vld), 32'(sv));
    chk(tag, "stat_byte", 32'(stat_byte), 32'(sb));
    chk(tag, "page_map", 32'(page_map), 32'(exp_map()));
  endtask

  function automatic string sel_tag(input logic [7:0] p);
    if (m_ix) return "R4";
    if (m_st && p >= 8'hC8) return "R6";
    return "R5";
  endfunction

  initial begin
    rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_page = 0; bus_off = 0;
    do_reset();
    // R1 reset state
    chk("R1", "page_map", 32'(page_map), 32'h0004);
    chk("R1", "sel_vld", 32'(sel_vld), 0);
    chk("R1", "stat_vld", 32'(stat_vld), 0);
    acc("R1", 8'hC0, 8'h15, 1, 0);
    acc("R1", 8'hC0, 8'h17, 1, 0);

    // sweep every combination of override, slot-3 switch and sticky flag
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset();
      if (cfg[2]) acc("R7", 8'hC3, 8'h00, 1, 0);
      if (cfg[1]) acc("R3", 8'hC0, 8'h0B, 0, 1);
      if (cfg[0]) acc("R2", 8'hC0, 8'h07, 0, 1);
      acc("R8", 8'hC0, 8'h15, 1, 0);
      acc("R8", 8'hC0, 8'h17, 1, 0);
      // writes into slot range at switch-like offsets must do nothing
      for (int p = 8'hC1; p <= 8'hCF; p++) acc("R9", 8'(p), 8'h06, 0, 1);
      acc("R9", 8'hCF, 8'hFF, 0, 1);
      // page sweep, C3 last so arming is visible afterwards
      for (int p = 8'hC1; p <= 8'hCF; p++)
        if (p != 8'hC3) acc(sel_tag(8'(p)), 8'(p), 8'h10, 1, 0);
      acc("R7", 8'hC3, 8'h20, 1, 0);
      acc(sel_tag(8'hC8), 8'hC8, 8'h00, 1, 0);
      // disarm address, routed with the old flag
      acc("R7", 8'hCF, 8'hFF, 1, 0);
      acc(sel_tag(8'hCA), 8'hCA, 8'h00, 1, 0);
      // both strobes: write only
      acc("R10", 8'hC3, 8'h00, 1, 1);
      acc("R10", 8'hC0, 8'h15, 1, 1);
      // reads outside the slot range
      acc("R11", 8'hC0, 8'h00, 1, 0);
      acc("R11", 8'hD0, 8'h00, 1, 0);
      acc("R11", 8'hBF, 8'hFF, 1, 0);
      // override clear also releases the sticky flag
      acc("R7", 8'hC3, 8'h00, 1, 0);
      acc("R2", 8'hC0, 8'h06, 0, 1);
      acc("R2", 8'hC0, 8'h15, 1, 0);
      acc("R3", 8'hC0, 8'h0A, 0, 1);
      acc("R3", 8'hC0, 8'h17, 1, 0);
    end
    // override set keeps sticky armed until the disarm read
    do_reset();
    acc("R7", 8'hC3, 8'h00, 1, 0);
    acc("R2", 8'hC0, 8'h07, 0, 1);
    acc("R7", 8'hCF, 8'hFF, 1, 0);
    acc("R2", 8'hC0, 8'h06, 0, 1);
    acc("R6", 8'hC9, 8'h00, 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule